// File: doc/BRIEF.md
# UART with Selectable Oversampling

This block is a byte-wide, register-mapped serial port in the 16550 tradition. A host reads and writes eight-bit registers over a simple single-cycle bus. Each register sits on its own 32-bit word, so the register index is address bits [5:2]. Bytes written to the data register go into a transmit FIFO and are shifted out on `serial_tx`. Frames arriving on `serial_rx` are checked, assembled and queued in a receive FIFO, where the host reads them back.

The baud rate comes from a fixed reference clock. A 16-bit divisor sets the rate, and an extra speed register sets the number of clocks per divisor step: 16, 8 or 4. The lower ratios let the port reach high bit rates without a faster reference clock. A frame has one start bit, 5 to 8 data bits sent LSB first, and one stop bit.

Bus reads are combinational: `bus_rdata` reflects the addressed register while `bus_en` is high with `bus_we` low. Any side effect of a read, such as popping the receive FIFO, takes place at the clock edge that ends the access. An access is ignored unless `bus_addr[1:0]` is zero and the address falls inside the ten-register window.

Top module: `uart_hs_core`

## Requirements
- R1: After reset, the registers read as follows: line control (index 3) 0x03, line status (index 5) 0x60, modem control (index 4) 0x00, interrupt ID (index 2) 0x01. After reset, `serial_tx` is high and `dtr_o` and `rts_o` are low.
- R2: Line-control bit 7 switches what register indices 0 and 1 reach. When the bit is set, they reach the low and high divisor bytes, and a write there sends nothing on `serial_tx`. When the bit is clear, index 0 is the data register and index 1 is the interrupt-enable register.
- R3: One bit lasts divisor × ratio reference clocks, with divisor = {high byte, low byte}. A divisor of 0 acts as 1. The speed register (index 9) sets the ratio: value 0 gives 16, value 1 gives 8, and values 2 and 3 give 4.
- R4: A transmitted frame is a low start bit, then N data bits LSB first, then one high stop bit, where N = 5 + line-control bits [1:0]. Data bits above N are not sent. The line idles high.
- R5: The receiver sets data-ready only for a valid frame: the start bit must still be low half a bit after the falling edge, each data bit is sampled at its middle, and the stop bit must be high. A short-word frame is stored right-aligned, with the upper bits zero.
- R6: A read of index 0 with line-control bit 7 clear returns the oldest received byte and removes it. Line-status bit 0 (data-ready) clears when the receive FIFO becomes empty.
- R7: The transmit FIFO holds 16 bytes while FIFO-control bit 0 is set, and 1 byte while it is clear. A write to a full transmit FIFO is dropped.
- R8: A write to FIFO control (index 2) stores bit 0 as the FIFO enable. The same write empties the receive FIFO if bit 1 is set, and the transmit FIFO if bit 2 is set. Interrupt-ID bits [7:6] read as 11 while the FIFOs are enabled.
- R9: Line-status bit 5 is set while the transmit FIFO is empty. Line-status bit 6 is set only while the transmit FIFO is empty and no frame is being shifted out.
- R10: Modem-control bit 0 drives `dtr_o` and bit 1 drives `rts_o`, from the clock edge after the write.
- R11: Scratch (index 7) and interrupt-enable read back the value last written. Modem status (index 6) and the auto-baud slot (index 8) always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; register index in bits [5:2] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| serial_rx | input | 1 | Serial input, idle high |
| serial_tx | output | 1 | Serial output, idle high |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |

## Verification
Two events can land on the transmit FIFO in the same cycle: a host write pushes a byte while the idle shifter pops the previous one. The bench provokes this with a burst of twenty back-to-back writes into an idle transmitter at four clocks per bit. The shifter's first pop coincides with the second push, and the FIFO then fills while the first frame is still on the line. The verdict is the byte stream decoded from `serial_tx`: exactly the first seventeen bytes must appear, in order. One byte is the one taken into the shifter, sixteen are held in the FIFO, and the last three are dropped.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;

   localparam logic [3:0] IDX_DATA  = 4'd0;
   localparam logic [3:0] IDX_IER   = 4'd1;
   localparam logic [3:0] IDX_FIFO  = 4'd2;
   localparam logic [3:0] IDX_LCR   = 4'd3;
   localparam logic [3:0] IDX_MCR   = 4'd4;
   localparam logic [3:0] IDX_LSR   = 4'd5;
   localparam logic [3:0] IDX_MSR   = 4'd6;
   localparam logic [3:0] IDX_SCR   = 4'd7;
   localparam logic [3:0] IDX_ABAUD = 4'd8;
   localparam logic [3:0] IDX_SPEED = 4'd9;

   typedef enum logic [1:0] {
      SER_IDLE,
      SER_START,
      SER_DATA,
      SER_STOP
   } ser_state_t;

   // log2 of clocks per divisor step: 16, 8 or 4
   function automatic logic [2:0] ratio_shift(input logic [1:0] speed);
      case (speed)
         2'd0:    ratio_shift = 3'd4;
         2'd1:    ratio_shift = 3'd3;
         default: ratio_shift = 3'd2;
      endcase
   endfunction

endpackage

// File: rtl/uart_hs_fifo.sv
module uart_hs_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             single,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("uart_hs_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = single ? !empty : (cnt == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wp] <= din;
   end

   // R7: a push into a full FIFO with no pop leaves the fill level unchanged
   p_drop_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (cnt == $past(cnt)));

   // R8: a clear empties the FIFO on the next edge
   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

endmodule

// File: rtl/uart_hs_tx.sv
module uart_hs_tx
   import uart_hs_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] bit_len,
   input  logic [1:0]       wlen,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   output logic             fifo_pop,
   output logic             busy,
   output logic             txd
);
   ser_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       bidx;
   logic [7:0]       shreg;
   logic             bit_end;

   assign bit_end  = (cnt == bit_len - 1'b1);
   assign fifo_pop = (st == SER_IDLE) && !fifo_empty;
   assign busy     = (st != SER_IDLE);

   always_comb begin
      case (st)
         SER_START: txd = 1'b0;
         SER_DATA:  txd = shreg[0];
         default:   txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SER_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         shreg <= '0;
      end else begin
         case (st)
            SER_IDLE: begin
               if (fifo_pop) begin
                  shreg <= fifo_data;
                  cnt   <= '0;
                  st    <= SER_START;
               end
            end
            SER_START: begin
               if (bit_end) begin
                  cnt  <= '0;
                  bidx <= '0;
                  st   <= SER_DATA;
               end else cnt <= cnt + 1'b1;
            end
            SER_DATA: begin
               if (bit_end) begin
                  cnt   <= '0;
                  shreg <= {1'b0, shreg[7:1]};
                  if (bidx == {1'b1, wlen}) st <= SER_STOP;
                  else bidx <= bidx + 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            default: begin
               if (bit_end) begin
                  cnt <= '0;
                  st  <= SER_IDLE;
               end else cnt <= cnt + 1'b1;
            end
         endcase
      end
   end

   // R4: taking a byte from the FIFO drives the start bit low on the next cycle
   p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !txd);

   // R4: the line is high whenever no frame is in progress
   p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

endmodule

// File: rtl/uart_hs_rx.sv
module uart_hs_rx
   import uart_hs_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] bit_len,
   input  logic [CNT_W-1:0] half_len,
   input  logic [1:0]       wlen,
   input  logic             rxd,
   output logic             push,
   output logic [7:0]       data
);
   ser_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       bidx;
   logic [7:0]       shreg;
   logic [1:0]       sync;
   logic             rxs;

   assign rxs  = sync[1];
   assign data = shreg >> (2'd3 - wlen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= 2'b11;
      else        sync <= {sync[0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SER_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         shreg <= '0;
         push  <= 1'b0;
      end else begin
         push <= 1'b0;
         case (st)
            SER_IDLE: begin
               if (!rxs) begin
                  cnt <= '0;
                  st  <= SER_START;
               end
            end
            SER_START: begin
               if (cnt == half_len - 1'b1) begin
                  cnt  <= '0;
                  bidx <= '0;
                  st   <= rxs ? SER_IDLE : SER_DATA;
               end else cnt <= cnt + 1'b1;
            end
            SER_DATA: begin
               if (cnt == bit_len - 1'b1) begin
                  cnt   <= '0;
                  shreg <= {rxs, shreg[7:1]};
                  if (bidx == {1'b1, wlen}) st <= SER_STOP;
                  else bidx <= bidx + 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            default: begin
               if (cnt == bit_len - 1'b1) begin
                  cnt  <= '0;
                  push <= rxs;
                  st   <= SER_IDLE;
               end else cnt <= cnt + 1'b1;
            end
         endcase
      end
   end

   // R5: a start bit that is high again at mid-bit returns the receiver to idle
   p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SER_START && cnt == half_len - 1'b1 && rxs) |=> (st == SER_IDLE));

endmodule

// File: rtl/uart_hs_core.sv
module uart_hs_core
   import uart_hs_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DIV_W      = 16,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              serial_rx,
   output logic              serial_tx,
   output logic              dtr_o,
   output logic              rts_o
);
   localparam int CNT_W = DIV_W + 4;

   initial begin
      if (ADDR_W < 6)  $error("uart_hs_core: ADDR_W must be at least 6");
      if (DIV_W != 16) $error("uart_hs_core: DIV_W must be 16 (two divisor bytes)");
   end

   // ---------------- bus decode ----------------
   logic       hit, wr, rd, dlab;
   logic [3:0] idx;

   assign idx  = bus_addr[5:2];
   assign hit  = bus_en && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 6) == '0) && (idx <= IDX_SPEED);
   assign wr   = hit && bus_we;
   assign rd   = hit && !bus_we;

   // ---------------- registers ----------------
   logic [7:0] div_lo, div_hi, ier, lcr, scr;
   logic [1:0] mcr, speed;
   logic       fifo_en;

   assign dlab = lcr[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lo  <= 8'h01;
         div_hi  <= 8'h00;
         ier     <= 8'h00;
         lcr     <= 8'h03;
         scr     <= 8'h00;
         mcr     <= 2'b00;
         speed   <= 2'b00;
         fifo_en <= 1'b0;
      end else if (wr) begin
         case (idx)
            IDX_DATA:  if (dlab) div_lo <= bus_wdata;
            IDX_IER:   if (dlab) div_hi <= bus_wdata; else ier <= bus_wdata;
            IDX_FIFO:  fifo_en <= bus_wdata[0];
            IDX_LCR:   lcr     <= bus_wdata;
            IDX_MCR:   mcr     <= bus_wdata[1:0];
            IDX_SCR:   scr     <= bus_wdata;
            IDX_SPEED: speed   <= bus_wdata[1:0];
            default:   ;
         endcase
      end
   end

   assign dtr_o = mcr[0];
   assign rts_o = mcr[1];

   // ---------------- baud timing ----------------
   logic [DIV_W-1:0] divisor;
   logic [CNT_W-1:0] bit_len, half_len;

   assign divisor  = ({div_hi, div_lo} == '0) ? DIV_W'(1) : {div_hi, div_lo};
   assign bit_len  = CNT_W'(divisor) << ratio_shift(speed);
   assign half_len = bit_len >> 1;

   // ---------------- FIFOs and shifters ----------------
   logic       tx_push, tx_pop, tx_empty, tx_full, tx_busy, tx_clr;
   logic       rx_push, rx_pop, rx_empty, rx_full, rx_clr;
   logic [7:0] tx_head, rx_head, rx_byte;

   assign tx_push = wr && (idx == IDX_DATA) && !dlab;
   assign rx_pop  = rd && (idx == IDX_DATA) && !dlab;
   assign tx_clr  = wr && (idx == IDX_FIFO) && bus_wdata[2];
   assign rx_clr  = wr && (idx == IDX_FIFO) && bus_wdata[1];

   uart_hs_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .single(!fifo_en),
      .push(tx_push), .din(bus_wdata), .pop(tx_pop), .dout(tx_head),
      .empty(tx_empty), .full(tx_full)
   );

   uart_hs_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .single(!fifo_en),
      .push(rx_push), .din(rx_byte), .pop(rx_pop), .dout(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   uart_hs_tx #(.CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .bit_len(bit_len), .wlen(lcr[1:0]),
      .fifo_empty(tx_empty), .fifo_data(tx_head), .fifo_pop(tx_pop),
      .busy(tx_busy), .txd(serial_tx)
   );

   uart_hs_rx #(.CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_len(bit_len), .half_len(half_len),
      .wlen(lcr[1:0]), .rxd(serial_rx), .push(rx_push), .data(rx_byte)
   );

   // ---------------- status and read mux ----------------
   logic lsr_dr, lsr_thre, lsr_temt;

   assign lsr_dr   = !rx_empty;
   assign lsr_thre = tx_empty;
   assign lsr_temt = tx_empty && !tx_busy;

   always_comb begin
      bus_rdata = 8'h00;
      if (rd) begin
         case (idx)
            IDX_DATA: bus_rdata = dlab ? div_lo : rx_head;
            IDX_IER:  bus_rdata = dlab ? div_hi : ier;
            IDX_FIFO: bus_rdata = {fifo_en, fifo_en, 6'b000001};
            IDX_LCR:  bus_rdata = lcr;
            IDX_MCR:  bus_rdata = {6'b0, mcr};
            IDX_LSR:  bus_rdata = {1'b0, lsr_temt, lsr_thre, 4'b0, lsr_dr};
            IDX_SCR:  bus_rdata = scr;
            IDX_SPEED: bus_rdata = {6'b0, speed};
            default:  bus_rdata = 8'h00;
         endcase
      end
   end

   // R9: transmitter-empty never shows while the holding FIFO still has data
   p_temt_needs_thre_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_temt |-> lsr_thre);

   // R10: the DTR pin follows the written modem-control bit
   p_dtr_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == IDX_MCR) |=> (dtr_o == $past(bus_wdata[0])));

   // R5: a completed frame makes data-ready visible on the next cycle
   p_push_sets_dr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && !rx_clr && !rx_full) |=> lsr_dr);

endmodule

// File: tb/tb_uart_hs_core.sv
module tb_uart_hs_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0, bus_we = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       serial_rx = 1'b1;
   logic       serial_tx, dtr_o, rts_o;

   always #10 clk = ~clk;

   uart_hs_core dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .serial_rx(serial_rx), .serial_tx(serial_tx), .dtr_o(dtr_o), .rts_o(rts_o)
   );

   int n_tests = 0, n_fail = 0;
   logic [1:0] model_mcr = 2'b00;
   int pin_mismatch = 0;
   logic [7:0] rv;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'(idx << 2); bus_wdata = d;
      @(posedge clk);
      #1 bus_en = 1'b0; bus_we = 1'b0;
      if (idx == 4) model_mcr = d[1:0];
   endtask

   task automatic rd(input int idx, output logic [7:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = 6'(idx << 2);
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_en = 1'b0;
   endtask

   // ---- behavioural line decoder for serial_tx ----
   int dec_L = 64, dec_nb = 8;
   logic [7:0] tx_seen [$];
   int dst = 0, dcnt = 0, low_run = 0, last_run = 0;
   logic [7:0] dbyte;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!serial_tx) low_run++;
         else begin
            if (low_run > 0) last_run = low_run;
            low_run = 0;
         end
         if (dst == 0) begin
            if (!serial_tx) begin dst = 1; dcnt = 0; dbyte = '0; end
         end else begin
            dcnt++;
            for (int s = 1; s <= dec_nb + 1; s++) begin
               if (dcnt == s * dec_L + dec_L / 2 - 1) begin
                  if (s <= dec_nb) dbyte[s-1] = serial_tx;
                  else begin
                     if (serial_tx) tx_seen.push_back(dbyte);
                     dst = 0;
                  end
               end
            end
         end
         if (dtr_o !== model_mcr[0] || rts_o !== model_mcr[1]) pin_mismatch++;
      end
   end

   task automatic send_rx(input logic [7:0] b, input int nb, input int L);
      @(negedge clk); serial_rx = 1'b0;
      repeat (L) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         serial_rx = b[i];
         repeat (L) @(negedge clk);
      end
      serial_rx = 1'b1;
      repeat (L) @(negedge clk);
   endtask

   task automatic set_baud(input logic [15:0] dv, input logic [1:0] sp, input int L);
      wr(3, 8'h83); wr(0, dv[7:0]); wr(1, dv[15:8]); wr(3, 8'h03); wr(9, {6'b0, sp});
      dec_L = L;
   endtask

   task automatic check_seen(input string tag, input logic [7:0] exp [$]);
      chk({tag, " byte count"}, tx_seen.size(), exp.size());
      for (int i = 0; i < exp.size() && i < tx_seen.size(); i++)
         chk(tag, tx_seen[i], exp[i]);
      tx_seen.delete();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] q [$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(3, rv); chk("R1 LCR reset", rv, 8'h03);
      rd(5, rv); chk("R1 LSR reset", rv, 8'h60);
      rd(4, rv); chk("R1 MCR reset", rv, 8'h00);
      rd(2, rv); chk("R1 IIR reset", rv, 8'h01);
      chk("R1 tx idle", serial_tx, 1);
      chk("R1 pins", {dtr_o, rts_o}, 0);

      // R11 scratch, IER, MSR, auto-baud slot
      wr(7, 8'hA5); rd(7, rv); chk("R11 scratch", rv, 8'hA5);
      wr(1, 8'h0F); rd(1, rv); chk("R11 IER", rv, 8'h0F);
      wr(6, 8'hFF); rd(6, rv); chk("R11 MSR", rv, 8'h00);
      wr(8, 8'hFF); rd(8, rv); chk("R11 auto-baud", rv, 8'h00);

      // R10 modem pins
      wr(4, 8'h03); @(negedge clk); chk("R10 dtr+rts", {dtr_o, rts_o}, 2'b11);
      wr(4, 8'h02); @(negedge clk); chk("R10 rts only", {dtr_o, rts_o}, 2'b01);

      // R2 divisor latch access
      wr(3, 8'h83); wr(0, 8'h05); wr(1, 8'h00);
      rd(0, rv); chk("R2 DLL", rv, 8'h05);
      rd(1, rv); chk("R2 DLM", rv, 8'h00);
      repeat (20) @(negedge clk);
      chk("R2 no frame from DLL write", serial_tx, 1);
      chk("R2 no bytes", tx_seen.size(), 0);
      wr(3, 8'h03); rd(1, rv); chk("R2 IER again", rv, 8'h0F);

      // R8 FIFO enable
      wr(2, 8'h07); rd(2, rv); chk("R8 IIR fifo bits", rv, 8'hC1);

      // R3 bit period for each speed setting (byte 0x00 => 9 low bits)
      set_baud(16'd3, 2'd0, 48); last_run = 0; wr(0, 8'h00);
      repeat (11 * 48 + 10) @(negedge clk); chk("R3 div3 x16", last_run, 9 * 48);
      set_baud(16'd2, 2'd1, 16); last_run = 0; wr(0, 8'h00);
      repeat (11 * 16 + 10) @(negedge clk); chk("R3 div2 x8", last_run, 9 * 16);
      set_baud(16'd1, 2'd3, 4); last_run = 0; wr(0, 8'h00);
      repeat (60) @(negedge clk); chk("R3 div1 speed3", last_run, 9 * 4);
      set_baud(16'd0, 2'd2, 4); last_run = 0; wr(0, 8'h00);
      repeat (60) @(negedge clk); chk("R3 div0 as 1", last_run, 9 * 4);
      q = '{8'h00, 8'h00, 8'h00, 8'h00}; check_seen("R4 zero frames", q);

      // R4 framing, 8 and 5 data bits
      wr(0, 8'hA5); repeat (60) @(negedge clk);
      wr(0, 8'h3C); repeat (60) @(negedge clk);
      q = '{8'hA5, 8'h3C}; check_seen("R4 8-bit", q);
      wr(3, 8'h00); dec_nb = 5;
      wr(0, 8'hFB); repeat (60) @(negedge clk);
      q = '{8'h1B}; check_seen("R4 5-bit", q);
      wr(3, 8'h03); dec_nb = 8;

      // R7 16-deep FIFO: burst of 20, push and pop collide on the second write
      for (int i = 0; i < 20; i++) wr(0, 8'(8'h40 + i));
      repeat (18 * 44) @(negedge clk);
      q.delete(); for (int i = 0; i < 17; i++) q.push_back(8'(8'h40 + i));
      check_seen("R7 burst overflow", q);

      // R7 FIFO disabled: one byte of holding
      set_baud(16'd3, 2'd0, 48);
      wr(2, 8'h06);
      wr(0, 8'h11); repeat (3) @(negedge clk);
      wr(0, 8'h22); wr(0, 8'h33);
      repeat (3 * 11 * 48) @(negedge clk);
      q = '{8'h11, 8'h22}; check_seen("R7 single holding", q);

      // R9 / R8 status while shifting, then TX clear
      wr(2, 8'h07);
      wr(0, 8'h5A); repeat (5) @(negedge clk);
      rd(5, rv); chk("R9 shifting, FIFO empty", rv, 8'h20);
      wr(0, 8'h66); wr(0, 8'h77);
      rd(5, rv); chk("R9 FIFO loaded", rv, 8'h00);
      wr(2, 8'h05);
      rd(5, rv); chk("R8 TX cleared", rv, 8'h20);
      repeat (3 * 11 * 48) @(negedge clk);
      rd(5, rv); chk("R9 all idle", rv, 8'h60);
      q = '{8'h5A}; check_seen("R8 only shifter byte", q);

      // R5 / R6 receive path at 16 clocks per bit
      set_baud(16'd1, 2'd0, 16);
      send_rx(8'h5A, 8, 16); send_rx(8'hC3, 8, 16);
      rd(5, rv); chk("R5 data-ready", rv & 8'h01, 1);
      rd(0, rv); chk("R6 first byte", rv, 8'h5A);
      rd(5, rv); chk("R6 still ready", rv & 8'h01, 1);
      rd(0, rv); chk("R6 second byte", rv, 8'hC3);
      rd(5, rv); chk("R6 ready cleared", rv & 8'h01, 0);

      // R5 short glitch is not a start bit
      @(negedge clk); serial_rx = 1'b0;
      repeat (4) @(negedge clk); serial_rx = 1'b1;
      repeat (12 * 16) @(negedge clk);
      rd(5, rv); chk("R5 glitch rejected", rv & 8'h01, 0);

      // R5 five-bit word, right-aligned
      wr(3, 8'h00);
      send_rx(8'h15, 5, 16);
      rd(0, rv); chk("R5 5-bit receive", rv, 8'h15);
      wr(3, 8'h03);

      // R8 RX clear
      send_rx(8'h99, 8, 16);
      wr(2, 8'h03);
      rd(5, rv); chk("R8 RX cleared", rv & 8'h01, 0);

      // R10 per-clock pin model
      chk("R10 per-clock pin compare", pin_mismatch, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule